// File: doc/BRIEF.md
# Two-Port Interrupt Status Aggregator

This block gathers interrupt causes from the ports of a storage host controller and turns them into a single level interrupt. Each port has its own cause register and mask register. The port logic reports events as one-cycle pulses, and each pulse latches a sticky cause bit. Software clears a cause by writing a 1 to it. A per-port pending bit is the OR of that port's unmasked causes. The pending bits, together with a software interrupt bit, form a host status halfword. That halfword has its own mask and a global summary bit.

A host control register holds a global-off bit, which holds the interrupt output low whatever the other state is. Access is over a simple synchronous register bus. The bus has halfword-aligned addresses and two byte-lane enables. The read data is combinational from the address.

Register layout, by byte address:
- 2·p: port p. The low byte is the cause status, write-1-to-clear. The high byte is the mask.
- 0x20: host status, read-only.
- 0x22: host control.
- 0x24: host mask.

Top module: `irq_agg`

## Requirements
- R1: After reset all cause bits are 0, every port mask reads 0xFF, the host mask reads 0xFFFF, host control reads 0x0100 (global-off set), and `irq_o` is low.
- R2: A pulse on event input `evt_i[6*p+k]` sets cause bit k of port p at the next clock edge. The causes are bit0 device removed, bit1 device attached, bit2 command complete, bit3 fatal error, bit4 device interrupt and bit5 reply queue not empty. Status bit6 always reads 0.
- R3: Writing the port low byte clears exactly the status bits written as 1. Writing back the value just read clears those bits, and writing 0xFF clears all of them.
- R4: If an event pulse arrives in the same cycle as a write-1-to-clear of the same bit, the bit stays set.
- R5: Port status bit7 (pending) reads 1 exactly when some bit in 0..5 is set in the status and clear in the mask. Bit7 has no mask counterpart, and writes to it have no effect.
- R6: The port mask sits in the high byte of the port register. A 1 blocks that cause from the pending bit, and writing the mask never changes the status.
- R7: Host status bit p (p = 0, 1) equals port p's pending bit. Host status bit14 equals host control bit14, the software interrupt request. All other host status bits below 15 read 0.
- R8: Host status bit15 is 1 exactly when some host status bit in 0..14 is set while the same host mask bit is 0.
- R9: `irq_o` equals host status bit15 when host control bit8 (global-off) is 0. It is forced low while that bit is 1.
- R10: Byte-lane enable `bus_be[0]` gates bits 7:0 of a write, and `bus_be[1]` gates bits 15:8. A disabled lane leaves its byte unchanged.
- R11: Writes to the host status address and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 12 | Event pulses, 6 per port, port p at bits 6p+5..6p |
| bus_addr | input | 6 | Byte address, bit0 ignored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Every register change, whether it comes from an event pulse or a bus write, is taken at the next rising edge. The result shows on `bus_rdata` and `irq_o` in that same cycle, because the pending and summary bits are combinational from the registered state.

The bench therefore drives its stimulus just after a falling edge and lets one rising edge pass. It then updates its model and compares reads and `irq_o` at the following falling edge. The read address is applied with no write or event active, so each comparison sees exactly one edge's worth of change.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizes and register word indices of the interrupt aggregator.
// Assumes at most 14 ports, so port bits never overlap host bits 14 and 15.
package irq_agg_pkg;
    localparam int CAUSE_W    = 6;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 6;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int IDX_HSTAT  = 16;   // byte 0x20
    localparam int IDX_HCTRL  = 17;   // byte 0x22
    localparam int IDX_HMASK  = 18;   // byte 0x24
    localparam int BIT_SOFT   = 14;
    localparam int BIT_GLOB   = 15;
    localparam int BIT_GOFF   = 8;
    localparam int BIT_PEND   = 7;
endpackage

// File: rtl/irq_port_regs.sv
// Module: per-port cause status (sticky, write-1-to-clear) and mask.
// Assumes bus writes are single-cycle strobes already decoded to this port.
module irq_port_regs #(
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt,
    input  logic               wr_en,
    input  logic [1:0]         be,
    input  logic [15:0]        wdata,
    output logic [7:0]         status,
    output logic [7:0]         mask,
    output logic               pend
);
    logic [CAUSE_W-1:0] cause_q;
    logic [7:0]         mask_q;
    logic [CAUSE_W-1:0] clr;

    // Clear vector: only the low byte lane of a write to this port clears.
    always_comb clr = (wr_en && be[0]) ? wdata[CAUSE_W-1:0] : '0;

    // Cause bits: events set, write-1 clears, events win a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr) | evt;
    end

    // Mask byte: upper byte lane only, set-to-block polarity.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= 8'hFF;
        else if (wr_en && be[1])   mask_q <= wdata[15:8];
    end

    // Pending summary and status view assembly.
    always_comb begin
        pend   = |(cause_q & ~mask_q[CAUSE_W-1:0]);
        status = '0;
        status[CAUSE_W-1:0] = cause_q;
        status[7] = pend;
    end

    assign mask = mask_q;
endmodule

// File: rtl/irq_host_regs.sv
// Module: host control, host mask, host status view, global summary and pin.
// Assumes NPORT <= 14; port pending bits arrive already combined per port.
module irq_host_regs #(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_pend,
    input  logic             wr_ctrl,
    input  logic             wr_mask,
    input  logic [1:0]       be,
    input  logic [15:0]      wdata,
    output logic [15:0]      hstat,
    output logic [15:0]      hctrl,
    output logic [15:0]      hmask,
    output logic             goff,
    output logic             glob,
    output logic             irq
);
    import irq_agg_pkg::*;

    logic        goff_q;
    logic        soft_q;
    logic [15:0] hmask_q;
    logic [14:0] raw;

    // Control bits live in the upper byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            goff_q <= 1'b1;
            soft_q <= 1'b0;
        end else if (wr_ctrl && be[1]) begin
            goff_q <= wdata[BIT_GOFF];
            soft_q <= wdata[BIT_SOFT];
        end
    end

    // Host mask, byte-lane gated, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hmask_q <= 16'hFFFF;
        else if (wr_mask) begin
            if (be[0]) hmask_q[7:0]  <= wdata[7:0];
            if (be[1]) hmask_q[15:8] <= wdata[15:8];
        end
    end

    // Raw host bits: one per port plus the software request.
    always_comb begin
        raw = '0;
        raw[NPORT-1:0] = port_pend;
        raw[BIT_SOFT]  = soft_q;
    end

    // Global summary, status view and gated pin.
    always_comb begin
        glob  = |(raw & ~hmask_q[14:0]);
        hstat = {glob, raw};
        hctrl = '0;
        hctrl[BIT_GOFF] = goff_q;
        hctrl[BIT_SOFT] = soft_q;
        irq   = glob & ~goff_q;
    end

    assign hmask = hmask_q;
    assign goff  = goff_q;
endmodule

// File: rtl/irq_agg.sv
// Module: top of the interrupt aggregator; bus decode, port array, read mux.
// Assumes halfword-aligned addresses (bit0 ignored) and a combinational read.
module irq_agg #(
    parameter int NPORT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT*irq_agg_pkg::CAUSE_W-1:0] evt_i,
    input  logic [irq_agg_pkg::ADDR_W-1:0] bus_addr,
    input  logic                          bus_we,
    input  logic [1:0]                    bus_be,
    input  logic [15:0]                   bus_wdata,
    output logic [15:0]                   bus_rdata,
    output logic                          irq_o
);
    import irq_agg_pkg::*;

    logic [IDX_W-1:0]  idx;
    logic [NPORT-1:0]  port_pend;
    logic [NPORT*8-1:0] port_stat;
    logic [NPORT*8-1:0] port_mask;
    logic [15:0]       hstat, hctrl, hmask;
    logic              host_goff, host_glob;

    assign idx = bus_addr[ADDR_W-1:1];

    // One register pair per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic wr_p;
        assign wr_p = bus_we && (idx == IDX_W'(p));
        irq_port_regs #(.CAUSE_W(CAUSE_W)) i_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_i[p*CAUSE_W +: CAUSE_W]),
            .wr_en  (wr_p),
            .be     (bus_be),
            .wdata  (bus_wdata),
            .status (port_stat[p*8 +: 8]),
            .mask   (port_mask[p*8 +: 8]),
            .pend   (port_pend[p])
        );
    end

    irq_host_regs #(.NPORT(NPORT)) i_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_pend (port_pend),
        .wr_ctrl   (bus_we && (idx == IDX_W'(IDX_HCTRL))),
        .wr_mask   (bus_we && (idx == IDX_W'(IDX_HMASK))),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .hstat     (hstat),
        .hctrl     (hctrl),
        .hmask     (hmask),
        .goff      (host_goff),
        .glob      (host_glob),
        .irq       (irq_o)
    );

    // Read mux: ports first, then host registers, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++)
            if (idx == IDX_W'(p)) bus_rdata = {port_mask[p*8 +: 8], port_stat[p*8 +: 8]};
        if (idx == IDX_W'(IDX_HSTAT)) bus_rdata = hstat;
        if (idx == IDX_W'(IDX_HCTRL)) bus_rdata = hctrl;
        if (idx == IDX_W'(IDX_HMASK)) bus_rdata = hmask;
    end
endmodule

// File: rtl/irq_agg_chk.sv
// Checker: temporal properties of the aggregator, bound to its top.
// Assumes it sees the top's flattened port status and host control state.
module irq_agg_chk #(
    parameter int NPORT = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPORT*6-1:0]    evt_i,
    input logic [5:0]            bus_addr,
    input logic                  bus_we,
    input logic [1:0]            bus_be,
    input logic [15:0]           bus_wdata,
    input logic                  irq_o,
    input logic [NPORT*8-1:0]    port_stat,
    input logic [15:0]           hstat,
    input logic                  host_goff
);
    // R1: reset leaves every cause clear, global-off set and the pin low.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (port_stat == '0 && host_goff && !irq_o));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        for (genvar k = 0; k < 6; k++) begin : g_k
            // R2/R4: an event always leaves its cause set, even against a clear.
            assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[p*6+k] |=> port_stat[p*8+k]);
            // R3: a 1 written to the low lane clears the cause when no event races it.
            assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr[5:1] == 5'(p) && bus_be[0] && bus_wdata[k] && !evt_i[p*6+k])
                |=> !port_stat[p*8+k]);
        end
        // R5: no cause bit set means no pending summary.
        assert_pend_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (port_stat[p*8 +: 6] == '0) |-> !port_stat[p*8+7]);
    end

    // R9: global-off holds the pin low.
    assert_goff_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_goff |-> !irq_o);

    // R8: the pin is only high when some host source is active.
    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (hstat[14:0] != '0));
endmodule

bind irq_agg irq_agg_chk #(.NPORT(NPORT)) i_irq_agg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .port_stat (port_stat),
    .hstat     (hstat),
    .host_goff (host_goff)
);

// File: tb/test_irq_agg.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic against a bench model.
module test_irq_agg;
    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [5:0]  m_st [NP];
    logic [7:0]  m_mk [NP];
    logic [15:0] m_hm;
    logic        m_goff, m_soft;

    always #2 clk = ~clk;

    irq_agg #(.NPORT(NP)) i_irq_agg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic m_pend(int p);
        return |(m_st[p] & ~m_mk[p][5:0]);
    endfunction

    function automatic logic [15:0] m_hstat();
        logic [15:0] h = '0;
        for (int p = 0; p < NP; p++) h[p] = m_pend(p);
        h[14] = m_soft;
        h[15] = |(h[14:0] & ~m_hm[14:0]);
        return h;
    endfunction

    function automatic logic m_irq();
        logic [15:0] h = m_hstat();
        return h[15] && !m_goff;
    endfunction

    function automatic logic [15:0] m_read(logic [5:0] a);
        int w = int'(a[5:1]);
        if (w < NP) return {m_mk[w], m_pend(w), 1'b0, m_st[w]};
        if (w == 16) return m_hstat();
        if (w == 17) return (16'(m_soft) << 14) | (16'(m_goff) << 8);
        if (w == 18) return m_hm;
        return 16'h0;
    endfunction

    task automatic m_reset();
        for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_mk[p] = 8'hFF; end
        m_hm = 16'hFFFF; m_goff = 1'b1; m_soft = 1'b0;
    endtask

    task automatic m_apply(logic [11:0] ev, logic we, logic [5:0] a, logic [1:0] be, logic [15:0] wd);
        int w = int'(a[5:1]);
        for (int p = 0; p < NP; p++) begin
            logic [5:0] clr = (we && w == p && be[0]) ? wd[5:0] : 6'h0;
            m_st[p] = (m_st[p] & ~clr) | ev[p*6 +: 6];
            if (we && w == p && be[1]) m_mk[p] = wd[15:8];
        end
        if (we && w == 17 && be[1]) begin m_goff = wd[8]; m_soft = wd[14]; end
        if (we && w == 18) begin
            if (be[0]) m_hm[7:0]  = wd[7:0];
            if (be[1]) m_hm[15:8] = wd[15:8];
        end
    endtask

    task automatic chk(logic [15:0] got, logic [15:0] exp, string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // One bus/event cycle: drive after a falling edge, update model at the rise.
    task automatic step(logic [11:0] ev, logic we, logic [5:0] a, logic [1:0] be, logic [15:0] wd);
        evt_i = ev; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk);
        m_apply(ev, we, a, be, wd);
        @(negedge clk);
        evt_i = '0; bus_we = 1'b0;
        chk({15'h0, irq_o}, {15'h0, m_irq()}, "R9");
    endtask

    task automatic rd(logic [5:0] a, string req);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        chk(bus_rdata, m_read(a), req);
    endtask

    task automatic wr(logic [5:0] a, logic [1:0] be, logic [15:0] wd);
        step('0, 1'b1, a, be, wd);
    endtask

    // Watchdog: an expired run is one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int unused_seed;
        unused_seed = $urandom(32'h1D5EED);
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at every register and the pin.
        rd(6'h00, "R1"); rd(6'h02, "R1"); rd(6'h20, "R1");
        rd(6'h22, "R1"); rd(6'h24, "R1");
        chk({15'h0, irq_o}, 16'h0, "R1");

        // R2: each cause of port 0 and port 1 latches from a pulse.
        step(12'b000001_101010, 1'b0, 6'h0, 2'b00, 16'h0);
        rd(6'h00, "R2"); rd(6'h02, "R2");
        // R6 / R5: unmask device-interrupt and reply-queue on port 0 -> pending.
        wr(6'h00, 2'b10, 16'hCF00);
        rd(6'h00, "R6");
        wr(6'h00, 2'b10, 16'hC000);
        rd(6'h00, "R5");
        // R7/R8/R9: unmask port 0 in host, release global-off.
        wr(6'h24, 2'b11, 16'hFFFE);
        rd(6'h20, "R7");
        chk({15'h0, irq_o}, 16'h0, "R9");
        wr(6'h22, 2'b10, 16'h0000);
        chk({15'h0, irq_o}, 16'h1, "R9");
        rd(6'h20, "R8");
        // R3: write back the value just read clears exactly those bits.
        v = bus_rdata;
        bus_addr = 6'h00; #0.5; v = bus_rdata;
        wr(6'h00, 2'b01, {8'h00, v[7:0] & 8'h0A});
        rd(6'h00, "R3");
        // R4: event collides with clear of the same bit.
        step(12'b000000_100000, 1'b1, 6'h00, 2'b01, 16'h00FF);
        rd(6'h00, "R4");
        // R10: low lane only leaves the mask byte; high lane only leaves status.
        wr(6'h00, 2'b01, 16'h1200);
        rd(6'h00, "R10");
        wr(6'h24, 2'b01, 16'h00FF);
        rd(6'h24, "R10");
        // R11: writes to host status and an unmapped address change nothing.
        wr(6'h20, 2'b11, 16'hFFFF);
        rd(6'h20, "R11"); rd(6'h00, "R11"); rd(6'h02, "R11");
        wr(6'h3E, 2'b11, 16'hFFFF);
        rd(6'h22, "R11"); rd(6'h24, "R11");
        // R7: software interrupt bit through host control.
        wr(6'h24, 2'b11, 16'hBFFF);
        wr(6'h22, 2'b10, 16'h4000);
        rd(6'h20, "R7");
        // R3: 0xFF clears everything on port 1.
        wr(6'h02, 2'b01, 16'h00FF);
        rd(6'h02, "R3");

        // Random traffic mixing events, writes and reads.
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] ev;
            logic [5:0]  a;
            logic [31:0] r;
            r  = $urandom;
            ev = (r[1:0] == 2'b00) ? 12'($urandom) : 12'h0;
            case (r[4:2])
                3'd0, 3'd1: a = 6'h00;
                3'd2, 3'd3: a = 6'h02;
                3'd4:       a = 6'h22;
                3'd5:       a = 6'h24;
                3'd6:       a = 6'h20;
                default:    a = 6'h3C;
            endcase
            step(ev, r[5], a, r[7:6], 16'($urandom));
            case (r[10:8])
                3'd0, 3'd1: rd(6'h00, "R5");
                3'd2, 3'd3: rd(6'h02, "R6");
                3'd4:       rd(6'h20, "R8");
                3'd5:       rd(6'h22, "R10");
                default:    rd(6'h24, "R10");
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule